// File: doc/BRIEF.md
# Indexed Block-Access Configuration Register Target

This block is the serial-bus target for the configuration registers of a clock generator. It holds eight byte-wide registers. A host writes them with an indexed block write: a starting index, a byte count, then the data bytes. It reads them with an indexed block read: the host writes the starting index, issues a repeated start and addresses the target for reading. The target first returns a count byte and then the register contents.

The raw SCL and SDA pins are oversampled by the system clock through two-flop synchronizers. The target only ever pulls SDA low, through `sda_oe`. All eight registers are presented in parallel on `regs_o` for the clock-control logic, with byte k on bits 8k+7:8k.

A static select input chooses one of two bus addresses. Some bits are read-only or reserved, and writes to them leave them unchanged:

| Byte | Writable bits | Fixed content |
|------|---------------|---------------|
| 0 | 3:0 | bits 7:4 read 1 |
| 1 | 5:3 and 1:0 | bits 7:6 read 0, bit 2 reads 1 |
| 2 | 3:0 | bits 7:4 read 1 |
| 3 | 7:4 | bits 3:0 read 1 |
| 4 | none | reserved, reads 0xFF |
| 5 | none | revision 0 in bits 7:4, vendor code 1 in bits 3:0 |
| 6 | none | device code 0x04 |
| 7 | 4:0 | read count; bits 7:5 read 0 |

Top module: `smb_cfg_target`

## Requirements
- R1: The target acknowledges address byte 0xD0/0xD1 (7-bit address 0x68) when `addr_sel` is 0, and 0xD4/0xD5 (address 0x6A) when it is 1. On any other address it drives no ACK for that byte or for any later byte until the next start condition. Registers are not changed in that time.
- R2: A write transaction consists of address with R/W bit 0, index N, count X, then data. The first X data bytes go to registers N, N+1, and so on. The target ACKs every byte, pulling SDA low in the ninth clock.
- R3: A read consists of address (write), index N, repeated start, then address with R/W bit 1. The target then sends, MSB first, the count byte X first and then the registers starting at N. X is taken from bits 4:0 of byte 7, with bits 7:5 of the count byte set to 0.
- R4: When the host answers a transmitted byte with NACK (SDA high in the ninth clock), the target stops driving SDA and stays off the bus until the next start.
- R5: The register index advances by one after each data byte, in both directions, and wraps from 7 to 0.
- R6: After reset, `regs_o` is 0x08_04_01_FF_5F_FF_06_FF (byte 7 down to byte 0) and `sda_oe` is 0.
- R7: Writes to the fixed bits listed in the table above leave their fixed values unchanged.
- R8: In a write, data bytes beyond the count X are acknowledged but not stored.
- R9: The target starts pulling SDA low only while the synchronized SCL is low. This means it never creates a start or stop condition itself.
- R10: A stop condition (SDA rising while SCL is high) releases SDA. Bytes that follow without a new start are not acknowledged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock pin level (asynchronous) |
| sda_i | input | 1 | Bus data pin level (asynchronous, wired-AND) |
| addr_sel | input | 1 | Latched bus-address select |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| regs_o | output | 64 | Register bank, byte k on bits 8k+7:8k |

## Verification
The hardest states to reach are the wrap of the index during a multi-byte transfer and a read that crosses from byte 7 to byte 0. Both need a complete write-then-read sequence with a repeated start and the right count value, so that the target is still sending when the index passes 7. The bench first programs byte 7 with a small count. It then starts block writes and reads at indices 5, 6 and 7, so that a short transfer crosses the wrap. It also sends one extra byte beyond the count, and a full write to a foreign address, to show that neither changes any register.

// File: rtl/smb_cfg_target.sv
module smb_cfg_target #(
  parameter logic [6:0] ADDR_LO   = 7'h68,
  parameter logic [6:0] ADDR_HI   = 7'h6A,
  parameter logic [3:0] REV_ID    = 4'h0,
  parameter logic [3:0] VENDOR_ID = 4'h1,
  parameter logic [7:0] DEVICE_ID = 8'h04
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        scl_i,
  input  logic        sda_i,
  input  logic        addr_sel,
  output logic        sda_oe,
  output logic [63:0] regs_o
);
  localparam logic [63:0] DEFAULTS = {8'h08, DEVICE_ID, REV_ID, VENDOR_ID,
                                      8'hFF, 8'h5F, 8'hFF, 8'h06, 8'hFF};
  localparam logic [63:0] WMASK    = {8'h1F, 8'h00, 8'h00, 8'h00,
                                      8'hF0, 8'h0F, 8'h3B, 8'h0F};

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_INDEX, S_COUNT, S_WDATA, S_TX} st_t;

  logic [1:0]  scl_sy, sda_sy;
  logic        scl_d, sda_d;
  st_t         st;
  logic [3:0]  bit_cnt;
  logic        ack_ph;
  logic [7:0]  sh, tx_sh, rem;
  logic [2:0]  idx;
  logic [63:0] bank_q;

  wire scl_s    = scl_sy[1];
  wire sda_s    = sda_sy[1];
  wire start_c  = scl_s & scl_d & sda_d & ~sda_s;
  wire stop_c   = scl_s & scl_d & ~sda_d & sda_s;
  wire scl_rise = scl_s & ~scl_d;
  wire scl_fall = ~scl_s & scl_d;

  wire [6:0] my_addr = addr_sel ? ADDR_HI : ADDR_LO;
  wire [5:0] bsel    = {idx, 3'b000};
  wire [7:0] rd_byte = bank_q[bsel +: 8];
  wire [7:0] next_tx = (rem != 8'd0) ? rd_byte : 8'hFF;
  wire [7:0] cnt_reg = {3'b000, bank_q[60:56]};
  wire       wr_en   = (st == S_WDATA) && !ack_ph && scl_fall &&
                       (bit_cnt == 4'd8) && (rem != 8'd0);

  assign regs_o = bank_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sy <= 2'b11;
      sda_sy <= 2'b11;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_sy <= {scl_sy[0], scl_i};
      sda_sy <= {sda_sy[0], sda_i};
      scl_d  <= scl_s;
      sda_d  <= sda_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      bit_cnt <= 4'd0;
      ack_ph  <= 1'b0;
      sh      <= 8'd0;
      tx_sh   <= 8'd0;
      rem     <= 8'd0;
      idx     <= 3'd0;
      sda_oe  <= 1'b0;
      bank_q  <= DEFAULTS;
    end else if (start_c) begin
      st      <= S_ADDR;
      bit_cnt <= 4'd0;
      ack_ph  <= 1'b0;
      sda_oe  <= 1'b0;
    end else if (stop_c) begin
      st      <= S_IDLE;
      ack_ph  <= 1'b0;
      sda_oe  <= 1'b0;
    end else begin
      case (st)
        S_IDLE: ;
        S_TX: begin
          if (!ack_ph) begin
            if (scl_rise) bit_cnt <= bit_cnt + 4'd1;
            if (scl_fall) begin
              if (bit_cnt == 4'd8) begin
                sda_oe <= 1'b0;
                ack_ph <= 1'b1;
              end else begin
                tx_sh  <= {tx_sh[6:0], 1'b0};
                sda_oe <= ~tx_sh[6];
              end
            end
          end else begin
            if (scl_rise) begin
              if (sda_s) st <= S_IDLE;
              else begin
                tx_sh <= next_tx;
                idx   <= idx + 3'd1;
                if (rem != 8'd0) rem <= rem - 8'd1;
              end
            end
            if (scl_fall) begin
              ack_ph  <= 1'b0;
              bit_cnt <= 4'd0;
              sda_oe  <= ~tx_sh[7];
            end
          end
        end
        default: begin
          if (!ack_ph) begin
            if (scl_rise) begin
              sh      <= {sh[6:0], sda_s};
              bit_cnt <= bit_cnt + 4'd1;
            end
            if (scl_fall && bit_cnt == 4'd8) begin
              ack_ph <= 1'b1;
              sda_oe <= 1'b1;
              case (st)
                S_ADDR: begin
                  if (sh[7:1] != my_addr) begin
                    st     <= S_IDLE;
                    ack_ph <= 1'b0;
                    sda_oe <= 1'b0;
                  end else if (sh[0]) begin
                    tx_sh <= cnt_reg;
                    rem   <= cnt_reg;
                  end
                end
                S_INDEX: idx <= sh[2:0];
                S_COUNT: rem <= sh;
                default: begin
                  if (wr_en) begin
                    bank_q[bsel +: 8] <= (sh & WMASK[bsel +: 8]) |
                                         (DEFAULTS[bsel +: 8] & ~WMASK[bsel +: 8]);
                    idx <= idx + 3'd1;
                    rem <= rem - 8'd1;
                  end
                end
              endcase
            end
          end else if (scl_fall) begin
            ack_ph  <= 1'b0;
            bit_cnt <= 4'd0;
            sda_oe  <= 1'b0;
            case (st)
              S_ADDR: begin
                if (sh[0]) begin
                  st     <= S_TX;
                  sda_oe <= ~tx_sh[7];
                end else st <= S_INDEX;
              end
              S_INDEX: st <= S_COUNT;
              S_COUNT: st <= S_WDATA;
              default: ;
            endcase
          end
        end
      endcase
    end
  end

  assert_quiet_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE) |-> !sda_oe);
  assert_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && idx == 3'd7) |=> (idx == 3'd0));
  assert_fixed_bytes_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> $stable(bank_q[55:32]));
  assert_count_down_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (rem == $past(rem) - 8'd1));
  assert_drive_scl_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_s);
  assert_stop_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
    stop_c |=> !sda_oe);
endmodule

// File: tb/smb_cfg_target_tb.sv
module smb_cfg_target_tb;
  localparam int CLK_PERIOD = 10;
  localparam int H = 20;
  localparam int NVEC = 11;
  localparam logic [23:0] VEC [0:NVEC-1] = '{
    24'h00_00_F0, 24'h00_0A_FA, 24'h01_00_04, 24'h01_FF_3F, 24'h02_00_F0,
    24'h03_00_0F, 24'h03_A5_AF, 24'h04_00_FF, 24'h05_FF_01, 24'h06_FF_04,
    24'h07_E3_03};

  logic clk = 1'b0, rst_n = 1'b0, m_scl = 1'b1, m_sda = 1'b1, addr_sel = 1'b0;
  logic sda_oe;
  logic [63:0] regs;
  wire sda_line = m_sda & ~sda_oe;
  int nvec = 0, nbad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  smb_cfg_target u_dut (.clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line),
                        .addr_sel(addr_sel), .sda_oe(sda_oe), .regs_o(regs));

  task automatic tick(input int n); repeat (n) @(negedge clk); endtask

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nvec++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic bus_start;
    m_sda = 1'b1; tick(H); m_scl = 1'b1; tick(H); m_sda = 1'b0; tick(H);
    m_scl = 1'b0; tick(H);
  endtask

  task automatic bus_stop;
    m_sda = 1'b0; tick(H); m_scl = 1'b1; tick(H); m_sda = 1'b1; tick(H);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; tick(H); m_scl = 1'b1; tick(H); m_scl = 1'b0;
    end
    m_sda = 1'b1; tick(H); m_scl = 1'b1; tick(H/2);
    ack = ~sda_line; tick(H/2); m_scl = 1'b0;
  endtask

  task automatic recv_byte(output logic [7:0] b, input logic nack);
    for (int i = 7; i >= 0; i--) begin
      tick(H); m_scl = 1'b1; tick(H/2); b[i] = sda_line; tick(H/2); m_scl = 1'b0;
    end
    m_sda = nack; tick(H); m_scl = 1'b1; tick(H); m_scl = 1'b0; tick(2);
    m_sda = 1'b1;
  endtask

  task automatic wr_seq(input logic [7:0] dev, input logic [7:0] idx, input logic [7:0] cnt,
                        input logic [31:0] data, input int n, output int acks);
    logic a;
    acks = 0;
    bus_start;
    send_byte(dev, a); acks += int'(a);
    send_byte(idx, a); acks += int'(a);
    send_byte(cnt, a); acks += int'(a);
    for (int i = 0; i < n; i++) begin
      send_byte(data[8*i +: 8], a); acks += int'(a);
    end
    bus_stop;
  endtask

  task automatic rd_seq(input logic [7:0] idx, input int n, output logic [31:0] got);
    logic a;
    logic [7:0] b;
    got = '0;
    bus_start;
    send_byte(8'hD0, a);
    send_byte(idx, a);
    bus_start;
    send_byte(8'hD1, a);
    for (int i = 0; i < n; i++) begin
      recv_byte(b, (i == n-1));
      got[8*i +: 8] = b;
    end
    tick(4);
    chk("R4 SDA released after host NACK", {63'd0, sda_oe}, 64'd0);
    bus_stop;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nvec++; nbad++;
      $display("FAIL watchdog expired actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end

  initial begin
    int acks;
    logic [31:0] got;
    logic a;
    tick(5);
    rst_n = 1'b1;
    tick(5);
    chk("R6 reset bank", regs, 64'h0804_01FF_5FFF_06FF);
    chk("R6 reset sda_oe", {63'd0, sda_oe}, 64'd0);

    for (int i = 0; i < NVEC; i++) begin
      wr_seq(8'hD0, VEC[i][23:16], 8'd1, {24'd0, VEC[i][15:8]}, 1, acks);
      chk($sformatf("R2 acks vec %0d", i), 64'(acks), 64'd4);
      chk($sformatf("R7 masked byte vec %0d", i), {56'd0, regs[8*VEC[i][18:16] +: 8]},
          {56'd0, VEC[i][7:0]});
    end

    wr_seq(8'hD0, 8'd0, 8'd4, 32'h44332211, 4, acks);
    chk("R2 block write acks", 64'(acks), 64'd7);
    chk("R2 block write bytes 0-3", {32'd0, regs[31:0]}, {32'd0, 32'h4FF326F1});

    wr_seq(8'hD0, 8'd6, 8'd3, 32'h00051CAA, 3, acks);
    chk("R5 write wrap byte 7", {56'd0, regs[63:56]}, 64'h1C);
    chk("R5 write wrap byte 0", {56'd0, regs[7:0]}, 64'hF5);
    chk("R7 byte 6 unchanged", {56'd0, regs[55:48]}, 64'h04);

    wr_seq(8'hD0, 8'd2, 8'd1, 32'h00000B0A, 2, acks);
    chk("R8 extra byte acked", 64'(acks), 64'd5);
    chk("R8 only counted byte stored", {48'd0, regs[31:16]}, 64'h4FFA);

    wr_seq(8'hD0, 8'd7, 8'd1, 32'h00000003, 1, acks);
    rd_seq(8'd5, 4, got);
    chk("R3 read count then bytes 5-7", {32'd0, got}, 64'h03040103);
    rd_seq(8'd7, 4, got);
    chk("R5 read wrap 7 to 0", {32'd0, got}, 64'h26F50303);

    addr_sel = 1'b1;
    tick(4);
    wr_seq(8'hD0, 8'd2, 8'd1, 32'h00000000, 1, acks);
    chk("R1 foreign address no ack", 64'(acks), 64'd0);
    chk("R1 foreign write ignored", {56'd0, regs[23:16]}, 64'hFA);
    wr_seq(8'hD4, 8'd2, 8'd1, 32'h00000005, 1, acks);
    chk("R1 select-high address acked", 64'(acks), 64'd4);
    chk("R1 select-high write stored", {56'd0, regs[23:16]}, 64'hF5);
    addr_sel = 1'b0;
    tick(4);

    send_byte(8'hD0, a);
    chk("R10 no ack after stop without start", {63'd0, a}, 64'd0);
    tick(4);
    chk("R10 SDA released", {63'd0, sda_oe}, 64'd0);
    bus_stop;

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule